// File: doc/BRIEF.md
# Multicart Outer/Inner Bank Mapper

This block sits between a CPU write port and the ROM address lines of a multi-game cartridge. Software selects a large outer region of ROM through a small file of system registers. Inside that region, it selects fine-grained banks through a command/index register and a data register, in the style of common scanline mappers. The block turns this register state into four 8 KB program bank numbers (one for each CPU window, 0x8000, 0xA000, 0xC000 and 0xE000), eight 1 KB picture-bus bank numbers (one for each 1 KB slot of the 8 KB pattern space) and a mirroring select.

Inner bank numbers never reach the outputs unchanged. A shift field in a system register sets how many low bits of each program bank come from the inner registers; the other bits come from an outer register. The same field also limits how many bits a data write may store. Two independent controls swap the program windows and the picture-bus halves. All outputs are combinational from the stored state. A write changes the state on the clock edge at which its strobe is sampled.

Top module: `mc_bank_mapper`

## Requirements
- R1: After reset, every system register reads zero except index 9 (0x3E) and index 10 (0x3F), and all six character registers are zero. The outputs are then program banks {0x000, 0x000, 0x03E, 0x03F}, character banks {0,1,0,1,0,0,0,0} and mirroring 0.
- R2: A strobed write to 0x4100..0x410F loads system register addr[3:0]. A write to 0x2018 loads index 12, and a write to 0x201A loads index 13. Any other address below 0x8000 has no effect.
- R3: In 0x8000..0xEFFF the address is reduced to addr & 0xE001. 0x8000 loads the command register (index 15), 0x8001 is a data write and 0xA000 is a mirroring write. The reduced values 0xA001, 0xC000, 0xC001, 0xE000 and 0xE001, every address from 0xF000 up, and any cycle with wr_en low change nothing.
- R4: A mirroring write sets mirror_sel to the inverse of data bit 0.
- R5: The program mask is 0x3F >> reg11[3:0]. A switchable window's bank is {reg0[7:4], (inner & mask) | (reg10 & ~mask)}, with inner register 7 for 0x8000 and inner register 8 for 0xA000.
- R6: A data write with command index 6 or 7 replaces only the masked bits of register 7 or 8, respectively. Bits outside the mask keep their old value.
- R7: A data write with command index 0..5 stores the data into character register [index], ANDed with 0x0F when reg13 bit 2 is 1 and with 0xFF >> reg11[7:4] when it is 0.
- R8: The character base is ({reg0[3:0], 8'h00} | reg12 << 1 | reg13[7:3]) << 3. Unswapped, slots 0/1 take character register 0 with bit 0 forced to 0 and to 1, slots 2/3 do the same with register 1, and slots 4..7 take registers 2..5. Each slot's inner value is ORed onto the base.
- R9: When command bit 7 is 1, slots 0..3 and slots 4..7 trade places.
- R10: When reg13 bit 0 and command bit 6 are both 1, the 0x8000 and 0xC000 program banks trade places. Either bit alone leaves them in place.
- R11: With reg13 bit 1 set, the 0xC000 window merges register 9 as in R5, and the 0xE000 window is {reg0[7:4], reg10} with no mask. With bit 1 clear, the two windows merge the constants 0xFE and 0xFF as in R5.
- R12: A write becomes visible on the outputs only after the clock edge that samples the strobe, and state is unchanged in any cycle without a decoded write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, sampled on the rising edge |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_bank | output | 48 | Four 12-bit 8 KB bank numbers, element k for window 0x8000 + k*0x2000 |
| chr_bank | output | 120 | Eight 15-bit 1 KB bank numbers, element k for slot k*0x400 |
| mirror_sel | output | 1 | Nametable mirroring select |

## Verification
Some properties are checked on every cycle. State holds when no write is decoded. A mirroring write inverts its data bit. A masked program write leaves the unmasked bits alone. A narrow character write clears the upper nibble. The outer bits of each program bank always equal the outer register. The 0xE000 window ends in all ones under the mask when fixed. The first slot pair differs only in bit 0. Other behaviour can only be shown by the directed scenarios, which compare against hand-worked bank numbers. This covers the exact merged values, both swap controls and their combinations, address aliasing and ignored addresses, and the point at which a write becomes visible relative to the clock edge.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 16;
  localparam int NUM_SYS  = 16;
  localparam int NUM_CHR  = 6;
  localparam int IDX_W    = $clog2(NUM_SYS);
  localparam int CMD_W    = 3;
  localparam int NUM_WIN  = 4;
  localparam int NUM_SLOT = 8;
  localparam int OUTER_W  = 4;
  localparam int PRG_W    = OUTER_W + DATA_W;
  localparam int CHR_SH   = 3;
  localparam int CHR_BLK_W = OUTER_W + DATA_W;
  localparam int CHR_W    = CHR_BLK_W + CHR_SH;
  localparam int SHIFT_W  = 4;

  // system register indices that logic decodes
  localparam int IX_OUTER  = 0;
  localparam int IX_PRG_A  = 7;
  localparam int IX_PRG_B  = 8;
  localparam int IX_FIX_C  = 9;
  localparam int IX_FIX_E  = 10;
  localparam int IX_SHIFT  = 11;
  localparam int IX_CHR_HI = 12;
  localparam int IX_MODE   = 13;
  localparam int IX_MIRR   = 14;
  localparam int IX_CMD    = 15;

  localparam logic [DATA_W-1:0] RST_FIX_C = 8'h3E;
  localparam logic [DATA_W-1:0] RST_FIX_E = 8'h3F;
  localparam logic [DATA_W-1:0] PRG_FULL  = 8'h3F;

  localparam logic [ADDR_W-1:0] A_CHR_HI   = 16'h2018;
  localparam logic [ADDR_W-1:0] A_MODE     = 16'h201A;
  localparam logic [ADDR_W-5:0] A_SYS_PAGE = 12'h410;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_SYS,
    WK_CMD,
    WK_DATA,
    WK_MIRR
  } wr_kind_e;

  typedef struct packed {
    wr_kind_e              kind;
    logic [IDX_W-1:0]      idx;
    logic [DATA_W-1:0]     data;
  } wr_req_t;

  function automatic logic [DATA_W-1:0] prg_mask(input logic [SHIFT_W-1:0] sh);
    return PRG_FULL >> sh;
  endfunction

  function automatic logic [DATA_W-1:0] chr_wmask(input logic [SHIFT_W-1:0] sh,
                                                  input logic narrow);
    return narrow ? 8'h0F : (8'hFF >> sh);
  endfunction

  function automatic logic [NUM_SYS-1:0][DATA_W-1:0] rst_image();
    logic [NUM_SYS-1:0][DATA_W-1:0] img;
    img = '0;
    img[IX_FIX_C] = RST_FIX_C;
    img[IX_FIX_E] = RST_FIX_E;
    return img;
  endfunction

endpackage

// File: rtl/mcm_wr_decode.sv
module mcm_wr_decode
  import mcm_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wr_req_t           req
);

  logic in_sys_page;
  logic in_mmc_area;
  logic [2:0] mmc_sel;

  assign in_sys_page = (wr_addr[ADDR_W-1:4] == A_SYS_PAGE);
  // 0x8000..0xEFFF only; top nibble 0xF is excluded
  assign in_mmc_area = wr_addr[ADDR_W-1] && (wr_addr[ADDR_W-2:ADDR_W-4] != 3'b111);
  // reduced key of addr & 0xE001 within the area: {a14, a13, a0}
  assign mmc_sel = {wr_addr[ADDR_W-2], wr_addr[ADDR_W-3], wr_addr[0]};

  always_comb begin
    req      = '0;
    req.kind = WK_NONE;
    req.data = wr_data;
    if (wr_en) begin
      if (in_sys_page) begin
        req.kind = WK_SYS;
        req.idx  = wr_addr[IDX_W-1:0];
      end else if (wr_addr == A_CHR_HI) begin
        req.kind = WK_SYS;
        req.idx  = IDX_W'(IX_CHR_HI);
      end else if (wr_addr == A_MODE) begin
        req.kind = WK_SYS;
        req.idx  = IDX_W'(IX_MODE);
      end else if (in_mmc_area) begin
        case (mmc_sel)
          3'b000:  req.kind = WK_CMD;
          3'b001:  req.kind = WK_DATA;
          3'b010:  req.kind = WK_MIRR;
          default: req.kind = WK_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mcm_regfile.sv
module mcm_regfile
  import mcm_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  wr_req_t                          req,
  output logic [DATA_W-1:0]                outer_q,
  output logic [DATA_W-1:0]                prg_a_q,
  output logic [DATA_W-1:0]                prg_b_q,
  output logic [DATA_W-1:0]                fix_c_q,
  output logic [DATA_W-1:0]                fix_e_q,
  output logic [SHIFT_W-1:0]               shift_lo_q,
  output logic [DATA_W-1:0]                chr_hi_q,
  output logic [4:0]                       mode_hi_q,
  output logic [1:0]                       mode_lo_q,
  output logic                             mirr_q,
  output logic [1:0]                       cmd_hi_q,
  output logic [NUM_CHR-1:0][DATA_W-1:0]   chr_q
);

  logic [NUM_SYS-1:0][DATA_W-1:0] sys_q, sys_nxt;
  logic [NUM_CHR-1:0][DATA_W-1:0] chr_r, chr_nxt;
  logic                           upd_en;
  logic [CMD_W-1:0]               cmd_idx;
  logic [IDX_W-1:0]               prg_tgt;
  logic [DATA_W-1:0]              pmask;
  logic [DATA_W-1:0]              cmask;

  assign cmd_idx = sys_q[IX_CMD][CMD_W-1:0];
  // command 6 targets index 7, command 7 targets index 8
  assign prg_tgt = IDX_W'(cmd_idx) + IDX_W'(1);
  assign pmask   = prg_mask(sys_q[IX_SHIFT][SHIFT_W-1:0]);
  assign cmask   = chr_wmask(sys_q[IX_SHIFT][DATA_W-1:SHIFT_W], sys_q[IX_MODE][2]);
  assign upd_en  = (req.kind != WK_NONE);

  // next-state
  always_comb begin
    sys_nxt = sys_q;
    chr_nxt = chr_r;
    case (req.kind)
      WK_SYS:  sys_nxt[req.idx] = req.data;
      WK_CMD:  sys_nxt[IX_CMD]  = req.data;
      WK_MIRR: sys_nxt[IX_MIRR] = {{(DATA_W-1){1'b0}}, ~req.data[0]};
      WK_DATA: begin
        if (cmd_idx < CMD_W'(NUM_CHR)) begin
          chr_nxt[cmd_idx] = req.data & cmask;
        end else begin
          sys_nxt[prg_tgt] = (sys_q[prg_tgt] & ~pmask) | (req.data & pmask);
        end
      end
      default: ;
    endcase
  end

  // state, clock enable written out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q <= rst_image();
      chr_r <= '0;
    end else if (upd_en) begin
      sys_q <= sys_nxt;
      chr_r <= chr_nxt;
    end
  end

  assign outer_q    = sys_q[IX_OUTER];
  assign prg_a_q    = sys_q[IX_PRG_A];
  assign prg_b_q    = sys_q[IX_PRG_B];
  assign fix_c_q    = sys_q[IX_FIX_C];
  assign fix_e_q    = sys_q[IX_FIX_E];
  assign shift_lo_q = sys_q[IX_SHIFT][SHIFT_W-1:0];
  assign chr_hi_q   = sys_q[IX_CHR_HI];
  assign mode_hi_q  = sys_q[IX_MODE][7:3];
  assign mode_lo_q  = sys_q[IX_MODE][1:0];
  assign mirr_q     = sys_q[IX_MIRR][0];
  assign cmd_hi_q   = sys_q[IX_CMD][7:6];
  assign chr_q      = chr_r;

  AST_RESET_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sys_q == rst_image()) && (chr_r == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req.kind == WK_NONE) |=> $stable(sys_q) && $stable(chr_r)); // R12

  AST_MIRR_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (req.kind == WK_MIRR) |=> (mirr_q == !$past(req.data[0]))); // R4

  AST_PRG_A_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req.kind == WK_DATA && cmd_idx == 3'd6) |=>
      (((sys_q[IX_PRG_A] ^ $past(sys_q[IX_PRG_A])) & ~$past(pmask)) == 8'h00)); // R6

  AST_PRG_B_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req.kind == WK_DATA && cmd_idx == 3'd7) |=>
      (((sys_q[IX_PRG_B] ^ $past(sys_q[IX_PRG_B])) & ~$past(pmask)) == 8'h00)); // R6

  for (genvar i = 0; i < NUM_CHR; i++) begin : g_chr_chk
    AST_CHR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (req.kind == WK_DATA && cmd_idx == CMD_W'(i) && sys_q[IX_MODE][2]) |=>
        (chr_r[i][7:4] == 4'h0)); // R7
  end

endmodule

// File: rtl/mcm_prg_map.sv
module mcm_prg_map
  import mcm_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [OUTER_W-1:0]              outer_hi,
  input  logic [DATA_W-1:0]               prg_a,
  input  logic [DATA_W-1:0]               prg_b,
  input  logic [DATA_W-1:0]               fix_c,
  input  logic [DATA_W-1:0]               fix_e,
  input  logic [SHIFT_W-1:0]              shift_lo,
  input  logic [1:0]                      mode_lo,
  input  logic                            cmd_swap,
  output logic [NUM_WIN-1:0][PRG_W-1:0]   prg_bank
);

  localparam logic [DATA_W-1:0] SECOND_LAST = 8'hFE;
  localparam logic [DATA_W-1:0] LAST        = 8'hFF;

  logic [DATA_W-1:0]            pmask;
  logic [DATA_W-1:0]            keep;
  logic [PRG_W-1:0]             pbase;
  logic [NUM_WIN-1:0][PRG_W-1:0] win;
  logic                         regs_drive_top;
  logic                         swap;

  function automatic logic [PRG_W-1:0] merge(input logic [PRG_W-1:0] base,
                                             input logic [DATA_W-1:0] inner,
                                             input logic [DATA_W-1:0] m,
                                             input logic [DATA_W-1:0] k);
    return base | {{OUTER_W{1'b0}}, (inner & m) | k};
  endfunction

  assign pmask          = prg_mask(shift_lo);
  assign keep           = fix_e & ~pmask;
  assign pbase          = {outer_hi, {DATA_W{1'b0}}};
  assign regs_drive_top = mode_lo[1];
  assign swap           = mode_lo[0] & cmd_swap;

  always_comb begin
    win[0] = merge(pbase, prg_a, pmask, keep);
    win[1] = merge(pbase, prg_b, pmask, keep);
    if (regs_drive_top) begin
      win[2] = merge(pbase, fix_c, pmask, keep);
      win[3] = pbase | {{OUTER_W{1'b0}}, fix_e};
    end else begin
      win[2] = merge(pbase, SECOND_LAST, pmask, keep);
      win[3] = merge(pbase, LAST, pmask, keep);
    end
  end

  assign prg_bank[0] = swap ? win[2] : win[0];
  assign prg_bank[1] = win[1];
  assign prg_bank[2] = swap ? win[0] : win[2];
  assign prg_bank[3] = win[3];

  AST_OUTER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_bank[0][PRG_W-1:DATA_W] == outer_hi) && (prg_bank[1][PRG_W-1:DATA_W] == outer_hi) &&
    (prg_bank[2][PRG_W-1:DATA_W] == outer_hi) && (prg_bank[3][PRG_W-1:DATA_W] == outer_hi)); // R5

  AST_LAST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_lo[1] |-> ((prg_bank[3][DATA_W-1:0] & prg_mask(shift_lo)) == prg_mask(shift_lo))); // R11

endmodule

// File: rtl/mcm_chr_map.sv
module mcm_chr_map
  import mcm_pkg::*;
#(
  parameter int SLOTS = NUM_SLOT
)
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [OUTER_W-1:0]               outer_lo,
  input  logic [DATA_W-1:0]                chr_hi,
  input  logic [4:0]                       mode_hi,
  input  logic [NUM_CHR-1:0][DATA_W-1:0]   chr_q,
  input  logic                             swap,
  output logic [SLOTS-1:0][CHR_W-1:0]      chr_bank
);

  localparam int HALF  = SLOTS / 2;
  localparam int PAIRS = HALF / 2;

  logic [CHR_BLK_W-1:0]          base_blk;
  logic [CHR_W-1:0]              cbase;
  logic [SLOTS-1:0][CHR_W-1:0]   raw;

  assign base_blk = {outer_lo, {DATA_W{1'b0}}}
                  | {{(OUTER_W-1){1'b0}}, chr_hi, 1'b0}
                  | {{(CHR_BLK_W-5){1'b0}}, mode_hi};
  assign cbase    = {base_blk, {CHR_SH{1'b0}}};

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    // lower half: pairs from the first registers; upper half: single banks
    localparam int SRC = (k < HALF) ? (k / 2) : (k - HALF + PAIRS);
    logic [DATA_W-1:0] inner;
    if (k < HALF) begin : g_pair
      if (k % 2 == 1) begin : g_odd
        assign inner = chr_q[SRC] | 8'h01;
      end else begin : g_even
        assign inner = chr_q[SRC] & 8'hFE;
      end
    end else begin : g_single
      assign inner = chr_q[SRC];
    end
    assign raw[k]      = cbase | {{(CHR_W-DATA_W){1'b0}}, inner};
    assign chr_bank[k] = swap ? raw[k ^ HALF] : raw[k];
  end

  AST_PAIR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (swap ? (chr_bank[HALF] ^ chr_bank[HALF+1]) : (chr_bank[0] ^ chr_bank[1])) == CHR_W'(1)); // R8

endmodule

// File: rtl/mc_bank_mapper.sv
module mc_bank_mapper
  import mcm_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_WIN-1:0][PRG_W-1:0]  prg_bank,
  output logic [NUM_SLOT-1:0][CHR_W-1:0] chr_bank,
  output logic                           mirror_sel
);

  wr_req_t                        req;
  logic [DATA_W-1:0]              outer_q;
  logic [DATA_W-1:0]              prg_a_q;
  logic [DATA_W-1:0]              prg_b_q;
  logic [DATA_W-1:0]              fix_c_q;
  logic [DATA_W-1:0]              fix_e_q;
  logic [SHIFT_W-1:0]             shift_lo_q;
  logic [DATA_W-1:0]              chr_hi_q;
  logic [4:0]                     mode_hi_q;
  logic [1:0]                     mode_lo_q;
  logic [1:0]                     cmd_hi_q;
  logic [NUM_CHR-1:0][DATA_W-1:0] chr_q;

  mcm_wr_decode u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .req     (req)
  );

  mcm_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .outer_q    (outer_q),
    .prg_a_q    (prg_a_q),
    .prg_b_q    (prg_b_q),
    .fix_c_q    (fix_c_q),
    .fix_e_q    (fix_e_q),
    .shift_lo_q (shift_lo_q),
    .chr_hi_q   (chr_hi_q),
    .mode_hi_q  (mode_hi_q),
    .mode_lo_q  (mode_lo_q),
    .mirr_q     (mirror_sel),
    .cmd_hi_q   (cmd_hi_q),
    .chr_q      (chr_q)
  );

  mcm_prg_map u_prg (
    .clk      (clk),
    .rst_n    (rst_n),
    .outer_hi (outer_q[DATA_W-1:DATA_W-OUTER_W]),
    .prg_a    (prg_a_q),
    .prg_b    (prg_b_q),
    .fix_c    (fix_c_q),
    .fix_e    (fix_e_q),
    .shift_lo (shift_lo_q),
    .mode_lo  (mode_lo_q),
    .cmd_swap (cmd_hi_q[0]),
    .prg_bank (prg_bank)
  );

  mcm_chr_map #(.SLOTS(NUM_SLOT)) u_chr (
    .clk      (clk),
    .rst_n    (rst_n),
    .outer_lo (outer_q[OUTER_W-1:0]),
    .chr_hi   (chr_hi_q),
    .mode_hi  (mode_hi_q),
    .chr_q    (chr_q),
    .swap     (cmd_hi_q[1]),
    .chr_bank (chr_bank)
  );

endmodule

// File: tb/mc_bank_mapper_bench.sv
module mc_bank_mapper_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_P     = CLK_PERIOD / 2;
  localparam int WATCHDOG   = 50000;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [15:0]       wr_addr;
  logic [7:0]        wr_data;
  logic [3:0][11:0]  prg_bank;
  logic [7:0][14:0]  chr_bank;
  logic              mirror_sel;

  int n_chk;
  int n_bad;
  bit done;

  mc_bank_mapper u_mc_bank_mapper (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prg_bank   (prg_bank),
    .chr_bank   (chr_bank),
    .mirror_sel (mirror_sel)
  );

  initial clk = 1'b0;
  always #(HALF_P) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic chk_prg(input string req, input logic [11:0] p0, input logic [11:0] p1,
                         input logic [11:0] p2, input logic [11:0] p3);
    chk(req, "prg 8000", 32'(prg_bank[0]), 32'(p0));
    chk(req, "prg A000", 32'(prg_bank[1]), 32'(p1));
    chk(req, "prg C000", 32'(prg_bank[2]), 32'(p2));
    chk(req, "prg E000", 32'(prg_bank[3]), 32'(p3));
  endtask

  task automatic t_reset_state();
    do_reset();
    chk_prg("R1", 12'h000, 12'h000, 12'h03E, 12'h03F);
    for (int k = 0; k < 8; k++)
      chk("R1", $sformatf("chr slot %0d", k), 32'(chr_bank[k]), (k < 4) ? 32'(k % 2) : 32'h0);
    chk("R1", "mirror", 32'(mirror_sel), 32'h0);
  endtask

  task automatic t_prg_merge();
    wr(16'h4100, 8'h50);
    wr(16'h410B, 8'h02);   // mask 0x0F
    wr(16'h410A, 8'hA5);
    wr(16'h8000, 8'h06);
    wr(16'h8001, 8'hFF);
    chk_prg("R5", 12'h5AF, 12'h5A0, 12'h5AE, 12'h5AF);
  endtask

  task automatic t_prg_keep();
    wr(16'h4107, 8'hF3);
    wr(16'h8001, 8'h05);   // command 6, mask 0x0F -> reg7 = 0xF5
    chk("R6", "narrow view", 32'(prg_bank[0]), 32'h5A5);
    wr(16'h410B, 8'h00);   // widen mask to 0x3F
    chk("R6", "kept upper bits", 32'(prg_bank[0]), 32'h5B5);
    wr(16'h8000, 8'h07);
    wr(16'h8001, 8'h7E);   // reg8 = 0x3E
    chk("R6", "cmd7 into A000", 32'(prg_bank[1]), 32'h5BE);
  endtask

  task automatic t_fixed_vs_reg();
    wr(16'h4109, 8'h12);
    wr(16'h201A, 8'h02);
    chk("R11", "reg C000", 32'(prg_bank[2]), 32'h592);
    chk("R11", "reg E000 unmasked", 32'(prg_bank[3]), 32'h5A5);
    wr(16'h201A, 8'h00);
    chk("R11", "fixed C000", 32'(prg_bank[2]), 32'h5BE);
    chk("R11", "fixed E000", 32'(prg_bank[3]), 32'h5BF);
  endtask

  task automatic t_prg_swap();
    wr(16'h8000, 8'h40);
    chk("R10", "cmd bit6 alone", 32'(prg_bank[0]), 32'h5B5);
    wr(16'h201A, 8'h01);
    chk_prg("R10", 12'h5BE, 12'h5BE, 12'h5B5, 12'h5BF);
    wr(16'h8000, 8'h00);
    chk("R10", "mode bit0 alone", 32'(prg_bank[0]), 32'h5B5);
    wr(16'h201A, 8'h00);
  endtask

  task automatic t_chr_layout();
    do_reset();
    wr(16'h4100, 8'h03);
    wr(16'h2018, 8'h81);
    wr(16'h201A, 8'h28);   // bits7:3 = 5, narrow off
    chk("R8", "base slot0", 32'(chr_bank[0]), 32'h1838);
    chk("R8", "base slot1", 32'(chr_bank[1]), 32'h1839);
    wr(16'h8000, 8'h00);
    wr(16'h8001, 8'h2D);
    chk("R8", "pair even", 32'(chr_bank[0]), 32'h183C);
    chk("R8", "pair odd", 32'(chr_bank[1]), 32'h183D);
    wr(16'h8000, 8'h01);
    wr(16'h8001, 8'h6B);
    chk("R8", "slot2", 32'(chr_bank[2]), 32'h187A);
    chk("R8", "slot3", 32'(chr_bank[3]), 32'h187B);
    wr(16'h8000, 8'h02);
    wr(16'h8001, 8'h41);
    chk("R8", "slot4", 32'(chr_bank[4]), 32'h1879);
  endtask

  task automatic t_chr_width();
    wr(16'h410B, 8'h40);   // data mask 0xFF >> 4
    wr(16'h8000, 8'h03);
    wr(16'h8001, 8'hB7);
    chk("R7", "shifted limit", 32'(chr_bank[5]), 32'h183F);
    wr(16'h410B, 8'h00);
    wr(16'h201A, 8'h2C);   // narrow bit set
    wr(16'h8000, 8'h04);
    wr(16'h8001, 8'hE6);
    chk("R7", "narrow limit", 32'(chr_bank[6]), 32'h183E);
  endtask

  task automatic t_chr_swap();
    wr(16'h8000, 8'h80);
    chk("R9", "slot0", 32'(chr_bank[0]), 32'h1879);
    chk("R9", "slot1", 32'(chr_bank[1]), 32'h183F);
    chk("R9", "slot4", 32'(chr_bank[4]), 32'h183C);
    chk("R9", "slot5", 32'(chr_bank[5]), 32'h183D);
  endtask

  task automatic t_mirror();
    wr(16'hA000, 8'h00);
    chk("R4", "inverted 0", 32'(mirror_sel), 32'h1);
    wr(16'hA001, 8'h01);
    chk("R3", "A001 ignored", 32'(mirror_sel), 32'h1);
    wr(16'hBFFE, 8'h01);
    chk("R4", "alias BFFE", 32'(mirror_sel), 32'h0);
  endtask

  task automatic t_ignored();
    logic [3:0][11:0] p_s;
    logic [7:0][14:0] c_s;
    logic             m_s;
    p_s = prg_bank;
    c_s = chr_bank;
    m_s = mirror_sel;
    wr(16'h4110, 8'h00);
    wr(16'h40FF, 8'h00);
    wr(16'h2019, 8'h00);
    wr(16'hC000, 8'h00);
    wr(16'hE001, 8'h00);
    wr(16'hF000, 8'h00);
    wr(16'hF001, 8'h00);
    wr(16'hA001, 8'h00);
    @(negedge clk);
    wr_addr = 16'h4100;
    wr_data = 8'h00;
    @(negedge clk);
    chk("R2", "prg unchanged", 32'(p_s != prg_bank), 32'h0);
    chk("R3", "chr unchanged", 32'(c_s != chr_bank), 32'h0);
    chk("R3", "mirror unchanged", 32'(mirror_sel), 32'(m_s));
  endtask

  task automatic t_timing();
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 16'h4100;
    wr_data = 8'h13;
    #(HALF_P - 1);
    chk("R12", "before edge", 32'(prg_bank[3][11:8]), 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R12", "after edge", 32'(prg_bank[3][11:8]), 32'h1);
  endtask

  initial begin
    n_chk   = 0;
    n_bad   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    t_reset_state();
    t_prg_merge();
    t_prg_keep();
    t_fixed_vs_reg();
    t_prg_swap();
    t_chr_layout();
    t_chr_width();
    t_chr_swap();
    t_mirror();
    t_ignored();
    t_timing();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule